// File: doc/BRIEF.md
# Bus Cycle Stepper

This block sits beside an 8-bit CPU with a Z80-style bus and controls its progress one bus cycle at a time. In stepping mode, any memory or I/O cycle the CPU begins is stalled by pulling the active-low wait line. Each clean press of the step button releases exactly that one cycle. Holding the run button lets cycles pass freely until it is let go. A mode switch selects free running, in which the wait line is never pulled.

When a cycle is first stalled, the block records the address bus, the data bus and the cycle kind. The display logic uses these as four address hex digits, two data hex digits and four status flags. All button inputs are synchronised to the CPU clock and debounced. A third button drives the CPU reset line and keeps the wait line released while it is active.

Top module: `cpu_stepper`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is raised, `cpu_wait_n` is 1, `cpu_reset_n` is 1, `disp_digits` is 0 and `disp_flags` is 0.
- R2: With `sw_single` at 0 (free run), `cpu_wait_n` stays 1 through every bus cycle.
- R3: With `sw_single` at 1 and the run button released, a clock edge that samples `cpu_mreq_n` or `cpu_iorq_n` low while no cycle is in progress drives `cpu_wait_n` to 0 at that same edge.
- R4: A step press held steadily releases a stalled cycle: `cpu_wait_n` returns to 1 on the DEB_CYC+3rd clock edge after the button input goes high.
- R5: One step press releases one cycle only. The next cycle start is stalled again, even while the step button is still held down.
- R6: While the run button is held (debounced), a stalled cycle is released on the DEB_CYC+3rd edge after the press, and later cycles pass. After release, the next cycle start is stalled again.
- R7: On the edge that stalls a cycle, `disp_digits[23:8]` takes the address and `disp_digits[7:0]` takes the data. `disp_flags` takes {fetch, read, write, I/O}: bit 3 = !`cpu_m1_n`, bit 2 = !`cpu_rd_n`, bit 1 = !`cpu_wr_n`, bit 0 = !`cpu_iorq_n`. These outputs then stay unchanged while the cycle stays stalled.
- R8: Once the reset button is debounced, `cpu_reset_n` goes to 0 on the DEB_CYC+2nd edge after the press. `cpu_wait_n` is 1 from the next edge for as long as the reset is active. After release, `cpu_reset_n` is 1.
- R9: A button pulse that lasts fewer than DEB_CYC clock cycles has no effect: a stalled cycle stays stalled.
- R10: Moving `sw_single` from 1 to 0 during a stalled cycle releases it on the third clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high block reset |
| cpu_mreq_n | input | 1 | Memory request, active low |
| cpu_iorq_n | input | 1 | I/O request, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_m1_n | input | 1 | Opcode fetch cycle marker, active low |
| cpu_addr | input | 16 | Address bus |
| cpu_data | input | 8 | Data bus |
| btn_step | input | 1 | Next-cycle button, high when pressed |
| btn_run | input | 1 | Run-while-held button, high when pressed |
| btn_reset | input | 1 | CPU reset button, high when pressed |
| sw_single | input | 1 | 1 selects stepping, 0 selects free run |
| cpu_wait_n | output | 1 | Wait request to the CPU, active low |
| cpu_reset_n | output | 1 | Reset to the CPU, active low |
| disp_digits | output | 24 | Captured address (23:8) and data (7:0) as six hex digits |
| disp_flags | output | 4 | Captured cycle kind {fetch, read, write, I/O} |

## Verification
A bus request sampled at an edge moves the wait line at that same edge, so every bus-driven expectation is queued right after that edge and compared at the following falling edge. Button effects go through two synchroniser stages, DEB_CYC stable cycles, one edge detector and the gate register. For these the bench counts falling edges from the press and requires the release exactly at DEB_CYC+3, or DEB_CYC+2 for the reset line. The mode switch skips the debouncer and is due on the third edge. Checks that something is ignored wait well past the debounce window before sampling.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 4;
    localparam int SNAP_W = ADDR_W + DATA_W;

    // gate states: no cycle, cycle stalled, cycle let through
    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_HOLD = 2'd1,
        GATE_PASS = 2'd2
    } gate_st_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } snap_t;

    // cycle kind as active-high flags {fetch, read, write, io}
    function automatic logic [FLAG_W-1:0] cycle_flags(
        input logic m1_n,
        input logic rd_n,
        input logic wr_n,
        input logic iorq_n
    );
        return {~m1_n, ~rd_n, ~wr_n, ~iorq_n};
    endfunction

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            cnt_q  <= '0;
            level  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] != level) begin
                if (cnt_q == CW'(DEB_CYC - 1)) begin
                    level <= sync_q[1];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/cycle_gate.sv
module cycle_gate
    import stepper_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stall_en,
    input  logic step,
    input  logic bus_active,
    output logic wait_n,
    output logic hold_start
);
    gate_st_t st_q;

    assign hold_start = (st_q == GATE_IDLE) && bus_active && stall_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= GATE_IDLE;
            wait_n <= 1'b1;
        end else begin
            case (st_q)
                GATE_IDLE: begin
                    if (bus_active) begin
                        if (stall_en) begin
                            st_q   <= GATE_HOLD;
                            wait_n <= 1'b0;
                        end else begin
                            st_q <= GATE_PASS;
                        end
                    end
                end
                GATE_HOLD: begin
                    if (step || !stall_en) begin
                        st_q   <= GATE_PASS;
                        wait_n <= 1'b1;
                    end
                end
                GATE_PASS: begin
                    if (!bus_active) st_q <= GATE_IDLE;
                end
                default: begin
                    st_q   <= GATE_IDLE;
                    wait_n <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/bus_capture.sv
module bus_capture
    import stepper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  snap_t             snap_in,
    input  logic [FLAG_W-1:0] flags_in,
    output snap_t             snap_q,
    output logic [FLAG_W-1:0] flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            flags_q <= '0;
        end else if (load) begin
            snap_q  <= snap_in;
            flags_q <= flags_in;
        end
    end
endmodule

// File: rtl/cpu_stepper.sv
module cpu_stepper
    import stepper_pkg::*;
#(
    parameter int DEB_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_mreq_n,
    input  logic              cpu_iorq_n,
    input  logic              cpu_rd_n,
    input  logic              cpu_wr_n,
    input  logic              cpu_m1_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              btn_step,
    input  logic              btn_run,
    input  logic              btn_reset,
    input  logic              sw_single,
    output logic              cpu_wait_n,
    output logic              cpu_reset_n,
    output logic [SNAP_W-1:0] disp_digits,
    output logic [FLAG_W-1:0] disp_flags
);
    localparam int NBTN    = 3;
    localparam int B_STEP  = 0;
    localparam int B_RUN   = 1;
    localparam int B_RESET = 2;

    logic [NBTN-1:0] btn_raw;
    logic [NBTN-1:0] btn_lvl;
    logic            step_lvl_q;
    logic [1:0]      mode_sync_q;
    logic            step_pulse;
    logic            stall_en;
    logic            gate_rst;
    logic            bus_active;
    logic            hold_start;
    snap_t           live_snap;
    snap_t           held_snap;

    assign btn_raw = {btn_reset, btn_run, btn_step};

    for (genvar i = 0; i < NBTN; i++) begin : g_btn
        btn_conditioner #(.DEB_CYC(DEB_CYC)) cond_i (
            .clk  (clk),
            .rst  (rst),
            .raw  (btn_raw[i]),
            .level(btn_lvl[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_lvl_q  <= 1'b0;
            mode_sync_q <= '0;
        end else begin
            step_lvl_q  <= btn_lvl[B_STEP];
            mode_sync_q <= {mode_sync_q[0], sw_single};
        end
    end

    assign step_pulse = btn_lvl[B_STEP] & ~step_lvl_q;
    assign stall_en   = mode_sync_q[1] & ~btn_lvl[B_RUN];
    assign gate_rst   = rst | btn_lvl[B_RESET];
    assign bus_active = ~cpu_mreq_n | ~cpu_iorq_n;
    assign live_snap  = '{addr: cpu_addr, data: cpu_data};

    cycle_gate gate_i (
        .clk       (clk),
        .rst       (gate_rst),
        .stall_en  (stall_en),
        .step      (step_pulse),
        .bus_active(bus_active),
        .wait_n    (cpu_wait_n),
        .hold_start(hold_start)
    );

    bus_capture cap_i (
        .clk     (clk),
        .rst     (rst),
        .load    (hold_start),
        .snap_in (live_snap),
        .flags_in(cycle_flags(cpu_m1_n, cpu_rd_n, cpu_wr_n, cpu_iorq_n)),
        .snap_q  (held_snap),
        .flags_q (disp_flags)
    );

    assign disp_digits = held_snap;
    assign cpu_reset_n = ~btn_lvl[B_RESET];
endmodule

// File: rtl/stepper_chk.sv
module stepper_chk
    import stepper_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_mreq_n,
    input logic              cpu_iorq_n,
    input logic              cpu_wait_n,
    input logic              cpu_reset_n,
    input logic [SNAP_W-1:0] disp_digits,
    input logic [FLAG_W-1:0] disp_flags
);
    // R1
    wait_free_in_reset_chk: assert property (@(posedge clk) rst |=> cpu_wait_n);

    // R3
    stall_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_wait_n) |-> $past(!cpu_mreq_n || !cpu_iorq_n));

    // R7
    held_snapshot_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_wait_n && $past(!cpu_wait_n)) |-> ($stable(disp_digits) && $stable(disp_flags)));

    // R8
    reset_releases_wait_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_reset_n |=> cpu_wait_n);
endmodule

bind cpu_stepper stepper_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cpu_mreq_n (cpu_mreq_n),
    .cpu_iorq_n (cpu_iorq_n),
    .cpu_wait_n (cpu_wait_n),
    .cpu_reset_n(cpu_reset_n),
    .disp_digits(disp_digits),
    .disp_flags (disp_flags)
);

// File: tb/cpu_stepper_tb_top.sv
module cpu_stepper_tb_top;
    localparam int DEB = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic b_step = 1'b0, b_run = 1'b0, b_reset = 1'b0, sw = 1'b0;
    logic        wait_n, reset_n;
    logic [23:0] digits;
    logic [3:0]  flags;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic       w;
        logic       r;
        bit         chk_disp;
        logic [23:0] d;
        logic [3:0]  f;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    cpu_stepper #(.DEB_CYC(DEB)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_mreq_n(mreq_n), .cpu_iorq_n(iorq_n), .cpu_rd_n(rd_n),
        .cpu_wr_n(wr_n), .cpu_m1_n(m1_n), .cpu_addr(addr), .cpu_data(data),
        .btn_step(b_step), .btn_run(b_run), .btn_reset(b_reset), .sw_single(sw),
        .cpu_wait_n(wait_n), .cpu_reset_n(reset_n),
        .disp_digits(digits), .disp_flags(flags)
    );

    task automatic tally(input bit ok, input string req, input int act, input int exp_v);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // monitor: compare queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            tally(wait_n === it.w, {it.req, " wait_n"}, int'(wait_n), int'(it.w));
            tally(reset_n === it.r, {it.req, " reset_n"}, int'(reset_n), int'(it.r));
            if (it.chk_disp) begin
                tally(digits === it.d, {it.req, " digits"}, int'(digits), int'(it.d));
                tally(flags === it.f, {it.req, " flags"}, int'(flags), int'(it.f));
            end
        end
    end

    // driver side: call right after a posedge, expectation checked at next negedge
    task automatic expect_now(input string req, input logic w, input logic r,
                              input bit cd, input logic [23:0] d, input logic [3:0] f);
        exp_t it;
        it.req = req; it.w = w; it.r = r; it.chk_disp = cd; it.d = d; it.f = f;
        sb_q.push_back(it);
    endtask

    task automatic edge_then;
        @(posedge clk); #1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_idle;
        mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    endtask

    task automatic bus_go(input logic mq, input logic io, input logic m1,
                          input logic rd, input logic wr,
                          input logic [15:0] a, input logic [7:0] dt);
        mreq_n = mq; iorq_n = io; m1_n = m1; rd_n = rd; wr_n = wr;
        addr = a; data = dt;
    endtask

    // count falling edges until sig reaches val
    task automatic edges_until(input bit which_reset, input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (((which_reset ? reset_n : wait_n) !== val) && n < 200);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        int n;
        cyc(3);
        rst = 1'b0;
        edge_then();
        expect_now("R1 after reset", 1'b1, 1'b1, 1'b1, 24'h0, 4'h0);

        // R2: free run
        @(negedge clk);
        bus_go(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1234, 8'h56);
        for (int i = 0; i < 4; i++) begin
            edge_then();
            expect_now("R2 free run", 1'b1, 1'b1, 1'b1, 24'h0, 4'h0);
        end
        @(negedge clk); bus_idle();
        sw = 1'b1;
        cyc(4);

        // R3 / R7: stall and capture (fetch+read => flags 1100)
        bus_go(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA55A, 8'h3C);
        edge_then();
        expect_now("R3 stall", 1'b0, 1'b1, 1'b1, 24'hA55A3C, 4'b1100);
        @(negedge clk);
        addr = 16'hFFFF; data = 8'h00;
        for (int i = 0; i < 3; i++) begin
            edge_then();
            expect_now("R7 stable", 1'b0, 1'b1, 1'b1, 24'hA55A3C, 4'b1100);
        end

        // R9: short glitch ignored
        @(negedge clk); b_step = 1'b1;
        cyc(8); b_step = 1'b0;
        cyc(30);
        edge_then();
        expect_now("R9 glitch ignored", 1'b0, 1'b1, 1'b1, 24'hA55A3C, 4'b1100);

        // R4: real press
        @(negedge clk); b_step = 1'b1;
        edges_until(1'b0, 1'b1, n);
        tally(n == DEB + 3, "R4 release latency", n, DEB + 3);
        cyc(5);
        edge_then();
        expect_now("R5 cycle passes", 1'b1, 1'b1, 1'b0, 24'h0, 4'h0);

        // R5: next cycle held although button still down (io write => 0011)
        @(negedge clk); bus_idle();
        cyc(2);
        bus_go(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0050, 8'h77);
        edge_then();
        expect_now("R5 next cycle held", 1'b0, 1'b1, 1'b1, 24'h005077, 4'b0011);
        @(negedge clk); b_step = 1'b0;
        cyc(25);
        edge_then();
        expect_now("R5 release no step", 1'b0, 1'b1, 1'b0, 24'h0, 4'h0);

        // R6: run while held
        @(negedge clk); b_run = 1'b1;
        edges_until(1'b0, 1'b1, n);
        tally(n == DEB + 3, "R6 run release latency", n, DEB + 3);
        bus_idle();
        cyc(2);
        bus_go(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0100, 8'h11);
        for (int i = 0; i < 3; i++) begin
            edge_then();
            expect_now("R6 running", 1'b1, 1'b1, 1'b1, 24'h005077, 4'b0011);
        end
        @(negedge clk); bus_idle();
        b_run = 1'b0;
        cyc(25);
        bus_go(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0200, 8'h22);
        edge_then();
        expect_now("R6 stalls after run", 1'b0, 1'b1, 1'b1, 24'h020022, 4'b0100);

        // R10: switch to free run releases
        @(negedge clk); sw = 1'b0;
        edges_until(1'b0, 1'b1, n);
        tally(n == 3, "R10 mode release latency", n, 3);
        bus_idle(); sw = 1'b1;
        cyc(4);

        // R8: reset button
        bus_go(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0300, 8'h33);
        edge_then();
        expect_now("R3 stall write", 1'b0, 1'b1, 1'b1, 24'h030033, 4'b0010);
        @(negedge clk); b_reset = 1'b1;
        edges_until(1'b1, 1'b0, n);
        tally(n == DEB + 2, "R8 reset latency", n, DEB + 2);
        edge_then();
        expect_now("R8 wait free in reset", 1'b1, 1'b0, 1'b0, 24'h0, 4'h0);
        @(negedge clk); bus_idle();
        cyc(2); b_reset = 1'b0;
        cyc(25);
        edge_then();
        expect_now("R8 reset released", 1'b1, 1'b1, 1'b0, 24'h0, 4'h0);

        // R1: block reset during a stall
        @(negedge clk);
        bus_go(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0400, 8'h44);
        edge_then();
        expect_now("R3 stall again", 1'b0, 1'b1, 1'b1, 24'h040044, 4'b1100);
        @(negedge clk); rst = 1'b1;
        edge_then();
        expect_now("R1 reset mid stall", 1'b1, 1'b1, 1'b1, 24'h0, 4'h0);
        @(negedge clk); rst = 1'b0; bus_idle();
        cyc(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule